// File: doc/BRIEF.md
# Sixteen-Channel Grayscale PWM Engine

This block turns sixteen 12-bit brightness levels into sixteen pulse-width modulated channel enables. A single shared counter advances on each rising edge of a slow grayscale clock. Every channel with a nonzero level switches on at the first count of a cycle. It switches off once the count has passed its level. The blank input holds the counter at zero and forces every channel off. Lowering blank starts a new PWM cycle, and raising it again ends that cycle.

To limit the current surge when many channels switch together, channel *i* is delayed by *i* × `STEP_TICKS` fast-clock cycles, on both its rising and its falling edge. Each channel also has a short "just switched on" flag. Error-detection logic uses this flag to tell a fresh turn-on from a settled output. The grayscale clock and blank arrive synchronous to the fast clock `clk`. The packed level vector comes from an external latch and takes effect at once, with no second buffer.

Top module: `gs_pwm_engine`

## Requirements
- R1: While `blank` is high, every `ch_en` and `ch_recent` bit is 0 in that same cycle, and the shared count is held at 0.
- R2: While `blank` is low, each rising edge of `gs_clk` advances the count by exactly one. After blank falls, counting starts again from 0.
- R3: On the first `gs_clk` rising edge after blank falls, every channel whose level is nonzero turns on. A channel whose level is 0 never turns on.
- R4: Channel i takes its level v from `gs_data[12*i +: 12]`. It stays on for exactly v grayscale clock periods, and goes off on the edge where the count before that edge equals v. This holds for v = 1 and for v = 4095.
- R5: The count saturates at 4095. If blank stays low beyond 4096 edges, no channel turns on again until the next blank pulse.
- R6: A change of `gs_data` is used from the next `gs_clk` edge on, within the running cycle.
- R7: Both edges of channel i appear exactly i × `STEP_TICKS` `clk` cycles after the matching edge of channel 0. The on-time of each channel is therefore unchanged.
- R8: `ch_recent[i]` is high during the first `RECENT_TICKS` cycles of each on period of `ch_en[i]`, or during the whole on period if it is shorter. It is low at all other times.
- R9: While `rst_n` is low, all outputs are 0 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock; the stagger steps count this clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gs_clk | input | 1 | Grayscale clock, synchronous to clk; its rising edges advance the count |
| blank | input | 1 | High forces all channels off and clears the count |
| gs_data | input | 192 | Sixteen 12-bit levels; channel i at bits 12*i+11 down to 12*i |
| ch_en | output | 16 | Staggered PWM enables, one per channel |
| ch_recent | output | 16 | Per-channel flag for the first RECENT_TICKS cycles of an on period |

## Verification
The bench measures the on-time of every channel in fast-clock cycles and compares it to the level times the grayscale period. The levels include 0, 1, 4094 and 4095. An off-by-one in the compare would show up as a two-cycle error, and would also either silence level 1 or let it run one period too long. Every cycle runs 4100 edges. A counter that wraps would therefore re-enable channels and inflate their measured time. The bench also checks that rise times step by exactly the stagger, and that blank cuts all outputs in the same cycle. A level rewritten mid-cycle must move the turn-off edge, which a design with a hidden second buffer would miss.

// File: rtl/gs_pwm_pkg.sv
// Shared constants for the grayscale PWM engine.
// Assumes: sixteen channels of 12-bit levels by default.
package gs_pwm_pkg;
    localparam int NCH_DEF = 16;
    localparam int GSW_DEF = 12;
    typedef logic [GSW_DEF-1:0] gs_level_t;
endpackage

// File: rtl/gs_count.sv
// Shared grayscale counter. Detects rising edges of gs_clk, advances a
// saturating count while blank is low and clears it while blank is high.
// Assumes: gs_clk is synchronous to clk and stays at each level at least one cycle.
module gs_count #(
    parameter int GSW = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           gs_clk,
    input  logic           blank,
    output logic           step,
    output logic [GSW-1:0] cnt
);
    localparam logic [GSW-1:0] CNT_MAX = {GSW{1'b1}};

    logic gs_prev;

    // one-cycle pulse on a grayscale edge outside blanking
    assign step = gs_clk & ~gs_prev & ~blank;

    // edge history and saturating count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gs_prev <= 1'b0;
            cnt     <= '0;
        end else begin
            gs_prev <= gs_clk;
            if (blank)
                cnt <= '0;
            else if (step && cnt != CNT_MAX)
                cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_CLEAR_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> cnt == '0); // R1
    AST_CNT_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !blank |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1)); // R2
    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank && cnt == CNT_MAX) |=> (cnt == CNT_MAX || cnt == '0)); // R5
endmodule

// File: rtl/gs_compare.sv
// Per-channel on/off decision. A channel turns on at the first grayscale
// edge of a cycle if its level is nonzero. It turns off on the edge where
// the count before that edge equals its level.
// Assumes: levels are used directly from gs_data, with no second buffer.
module gs_compare #(
    parameter int NCH = 16,
    parameter int GSW = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               blank,
    input  logic               step,
    input  logic [GSW-1:0]     cnt,
    input  logic [NCH*GSW-1:0] gs_data,
    output logic [NCH-1:0]     raw_on
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [GSW-1:0] lvl;
        assign lvl = gs_data[i*GSW +: GSW];

        // raw enable: set at count zero, cleared on equality or blank
        always_ff @(posedge clk) begin
            if (!rst_n)
                raw_on[i] <= 1'b0;
            else if (blank)
                raw_on[i] <= 1'b0;
            else if (step) begin
                if (cnt == '0)
                    raw_on[i] <= (lvl != '0);
                else if (cnt == lvl)
                    raw_on[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/gs_stagger.sv
// Delays channel i by i*STEP_TICKS clk cycles and gates all channels with
// blank. The delay lines are cleared while blank is high, so no stale
// ones leak out once blank falls.
// Assumes: STEP_TICKS*(NCH-1) stays small (a shift register per channel).
module gs_stagger #(
    parameter int NCH        = 16,
    parameter int STEP_TICKS = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           blank,
    input  logic [NCH-1:0] raw_on,
    output logic [NCH-1:0] ch_en
);
    logic [NCH-1:0] dly;

    for (genvar i = 0; i < NCH; i++) begin : g_dly
        localparam int DEPTH = i * STEP_TICKS;
        if (DEPTH == 0) begin : g_none
            assign dly[i] = raw_on[i];
        end else if (DEPTH == 1) begin : g_one
            logic sr;
            // single-stage delay, cleared by blank
            always_ff @(posedge clk) begin
                if (!rst_n || blank) sr <= 1'b0;
                else                 sr <= raw_on[i];
            end
            assign dly[i] = sr;
        end else begin : g_many
            logic [DEPTH-1:0] sr;
            // multi-stage delay, cleared by blank
            always_ff @(posedge clk) begin
                if (!rst_n || blank) sr <= '0;
                else                 sr <= {sr[DEPTH-2:0], raw_on[i]};
            end
            assign dly[i] = sr[DEPTH-1];
        end
    end

    // blank wins over every delayed enable
    assign ch_en = dly & {NCH{~blank}};
endmodule

// File: rtl/gs_recent.sv
// Per-channel flag that is high for the first RECENT_TICKS cycles of each
// on period of a channel enable.
// Assumes: RECENT_TICKS >= 1.
module gs_recent #(
    parameter int NCH          = 16,
    parameter int RECENT_TICKS = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] en,
    output logic [NCH-1:0] recent
);
    localparam int RCW = $clog2(RECENT_TICKS + 1);

    logic [NCH-1:0] en_prev;
    logic [NCH-1:0] rise;

    assign rise = en & ~en_prev;

    // enable history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) en_prev <= '0;
        else        en_prev <= en;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [RCW-1:0] rc;
        // remaining flag cycles after the rising cycle
        always_ff @(posedge clk) begin
            if (!rst_n || !en[i]) rc <= '0;
            else if (rise[i])     rc <= RCW'(RECENT_TICKS - 1);
            else if (rc != '0)    rc <= rc - 1'b1;
        end
        assign recent[i] = en[i] & (rise[i] | (rc != '0));

        AST_RECENT_ONLY_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
            (rc != '0) |-> $past(en[i])); // R8
    end
endmodule

// File: rtl/gs_pwm_engine.sv
// Top of the sixteen-channel grayscale PWM engine: shared counter,
// per-channel compare, index-proportional stagger and recent-on flags.
// Assumes: gs_clk and blank are synchronous to clk.
module gs_pwm_engine
    import gs_pwm_pkg::*;
#(
    parameter int NCH          = NCH_DEF,
    parameter int GSW          = GSW_DEF,
    parameter int STEP_TICKS   = 2,
    parameter int RECENT_TICKS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gs_clk,
    input  logic               blank,
    input  logic [NCH*GSW-1:0] gs_data,
    output logic [NCH-1:0]     ch_en,
    output logic [NCH-1:0]     ch_recent
);
    logic           step;
    logic [GSW-1:0] cnt;
    logic [NCH-1:0] raw_on;

    gs_count #(.GSW(GSW)) u_count (
        .clk(clk), .rst_n(rst_n), .gs_clk(gs_clk), .blank(blank),
        .step(step), .cnt(cnt)
    );

    gs_compare #(.NCH(NCH), .GSW(GSW)) u_compare (
        .clk(clk), .rst_n(rst_n), .blank(blank), .step(step), .cnt(cnt),
        .gs_data(gs_data), .raw_on(raw_on)
    );

    gs_stagger #(.NCH(NCH), .STEP_TICKS(STEP_TICKS)) u_stagger (
        .clk(clk), .rst_n(rst_n), .blank(blank), .raw_on(raw_on), .ch_en(ch_en)
    );

    gs_recent #(.NCH(NCH), .RECENT_TICKS(RECENT_TICKS)) u_recent (
        .clk(clk), .rst_n(rst_n), .en(ch_en), .recent(ch_recent)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        AST_RAW_ON_AT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(raw_on[i]) |-> cnt == GSW'(1)); // R3
    end
endmodule

// File: tb/test_gs_pwm_engine.sv
module test_gs_pwm_engine;
    import gs_pwm_pkg::*;

    localparam int NCH    = 16;
    localparam int STEP   = 2;
    localparam int RECENT = 8;
    localparam int GSPER  = 2;          // clk cycles per grayscale period
    localparam int EDGES  = 4100;       // past 4096 to exercise saturation

    // frame table: mode (0 all equal, 1 hashed, 2 corners) and seed
    localparam int NFR = 8;
    localparam int FR_MODE [NFR] = '{0, 0, 2, 1, 1, 1, 0, 1};
    localparam int FR_SEED [NFR] = '{4095, 1, 0, 123, 2047, 3001, 0, 7};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gs_clk = 1'b0;
    logic blank = 1'b1;
    logic [NCH*12-1:0] gs_data = '0;
    logic [NCH-1:0] ch_en, ch_recent;

    int tests = 0, fails = 0, cyc = 0;
    int en_cnt [NCH];
    int rec_cnt [NCH];
    int rise_t [NCH];

    always #10 clk = ~clk;

    gs_pwm_engine #(.STEP_TICKS(STEP), .RECENT_TICKS(RECENT)) i_gs_pwm_engine (
        .clk(clk), .rst_n(rst_n), .gs_clk(gs_clk), .blank(blank),
        .gs_data(gs_data), .ch_en(ch_en), .ch_recent(ch_recent)
    );

    // monitor: samples 5 ns after each rising edge
    always begin
        @(posedge clk);
        #5;
        cyc++;
        for (int i = 0; i < NCH; i++) begin
            if (ch_en[i]) begin
                en_cnt[i]++;
                if (rise_t[i] < 0) rise_t[i] = cyc;
            end
            if (ch_recent[i]) rec_cnt[i]++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic gs_level_t gen_val(input int mode, input int seed, input int ch);
        case (mode)
            0: gen_val = gs_level_t'(seed);
            1: gen_val = gs_level_t'((seed * (ch + 3) + ch * ch * 977) % 4096);
            default: case (ch % 4)
                0: gen_val = 12'd0;
                1: gen_val = 12'd1;
                2: gen_val = 12'd4094;
                default: gen_val = 12'd4095;
            endcase
        endcase
    endfunction

    function automatic logic [NCH*12-1:0] pack(input int mode, input int seed);
        pack = '0;
        for (int i = 0; i < NCH; i++) pack[i*12 +: 12] = gen_val(mode, seed, i);
    endfunction

    task automatic clear_meas();
        for (int i = 0; i < NCH; i++) begin
            en_cnt[i] = 0; rec_cnt[i] = 0; rise_t[i] = -1;
        end
    endtask

    // one PWM cycle: blank pulse, n edges, optional data change at edge chg_at
    task automatic run_frame(input logic [NCH*12-1:0] da, input logic [NCH*12-1:0] db,
                             input int chg_at, input int n_edges);
        @(negedge clk);
        blank = 1'b1; gs_clk = 1'b0; gs_data = da;
        repeat (3) @(negedge clk);
        clear_meas();
        blank = 1'b0;
        repeat (2) @(negedge clk);
        for (int e = 1; e <= n_edges; e++) begin
            if (e == chg_at) gs_data = db;
            gs_clk = 1'b1;
            @(negedge clk);
            gs_clk = 1'b0;
            @(negedge clk);
        end
        repeat (15 * STEP + 12) @(negedge clk);
    endtask

    task automatic check_frame(input logic [NCH*12-1:0] d);
        int v0;
        v0 = int'(d[11:0]);
        for (int i = 0; i < NCH; i++) begin
            int v, er;
            v = int'(d[i*12 +: 12]);
            er = (v * GSPER < RECENT) ? v * GSPER : RECENT;
            // R4 / R5: on-time equals level, no re-enable after saturation
            check(en_cnt[i] == v * GSPER, "R4 on-time", en_cnt[i], v * GSPER);
            check(rec_cnt[i] == er, "R8 recent width", rec_cnt[i], er);
            if (v != 0 && v0 != 0)
                check(rise_t[i] - rise_t[0] == i * STEP, "R7 stagger",
                      rise_t[i] - rise_t[0], i * STEP);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        clear_meas();
        // R9: reset state
        repeat (4) @(negedge clk);
        check(ch_en == '0, "R9 reset en", int'(ch_en), 0);
        check(ch_recent == '0, "R9 reset recent", int'(ch_recent), 0);
        rst_n = 1'b1;

        // table walk: R3 R4 R5 R7 R8
        for (int f = 0; f < NFR; f++) begin
            logic [NCH*12-1:0] d;
            d = pack(FR_MODE[f], FR_SEED[f]);
            run_frame(d, d, 0, EDGES);
            check_frame(d);
        end

        // R6: level of channel 3 rewritten from 100 to 60 at edge 50
        begin
            logic [NCH*12-1:0] da, db;
            da = pack(0, 100);
            db = da;
            db[3*12 +: 12] = 12'd60;
            run_frame(da, db, 50, EDGES);
            check(en_cnt[3] == 60 * GSPER, "R6 mid-cycle change", en_cnt[3], 60 * GSPER);
            check(en_cnt[4] == 100 * GSPER, "R6 untouched channel", en_cnt[4], 100 * GSPER);
        end

        // R1 / R2 / R3: blank cuts outputs at once and the cycle restarts
        @(negedge clk);
        blank = 1'b1; gs_data = pack(0, 4095);
        repeat (3) @(negedge clk);
        blank = 1'b0;
        repeat (2) @(negedge clk);
        for (int e = 0; e < 20; e++) begin
            gs_clk = 1'b1; @(negedge clk); gs_clk = 1'b0; @(negedge clk);
        end
        check(ch_en == 16'hFFFF, "R3 all on", int'(ch_en), 16'hFFFF);
        blank = 1'b1;
        #1;
        check(ch_en == '0, "R1 blank en", int'(ch_en), 0);
        check(ch_recent == '0, "R1 blank recent", int'(ch_recent), 0);
        repeat (3) @(negedge clk);
        blank = 1'b0;
        repeat (3) @(negedge clk);
        check(ch_en == '0, "R2 no edge no count", int'(ch_en), 0);
        gs_clk = 1'b1;
        @(posedge clk); #5;
        check(ch_en[0] == 1'b1, "R2 restart from zero", int'(ch_en[0]), 1);
        check(ch_recent[0] == 1'b1, "R8 recent at rise", int'(ch_recent[0]), 1);
        @(negedge clk);
        gs_clk = 1'b0;

        // R9: reset in the middle of an on period
        rst_n = 1'b0;
        @(posedge clk); #5;
        check(ch_en == '0, "R9 reset mid-cycle", int'(ch_en), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule